// File: doc/BRIEF.md
# Serial Gain Adjustment Link

This block moves per-channel gain codes from a controller to an amplifier module over a slow three-line serial bus: a bit clock, a data line and a load strobe. The transmitting side runs from the system clock. When the host issues a command holding a module address, a channel address and a gain byte, it sends one 17-bit frame at a fixed, very low bit rate. The default is 40000 system clocks per bit, which gives 500 bit/s from 20 MHz. The transmitter keeps all three lines low unless gain-adjust mode is selected, so the amplifiers see no activity during normal running.

The receiving side sits in the amplifier module and takes the three lines from a cable, which makes them asynchronous to its clock. It resynchronises them, counts clock pulses and shifts the data in. It acts only when the load strobe rises. If the frame carried exactly 17 pulses and its module field equals the receiver's strap value, the gain byte goes into one of 16 channel registers. A readback port lets the host check every register. The registers clear at reset, so the host must rewrite and check every channel after each power-up.

The top module holds both ends. The transmitter's bus outputs and the receiver's bus inputs are separate ports, and the system wiring joins them through the cable.

Top module: `gain_link_top`

## Requirements
- R1: A frame is sent most significant bit first: module address [4:0], then channel address [3:0], then gain [7:0]. Data changes only while the serial clock is low and holds steady while it is high.
- R2: Each frame carries exactly 17 serial clock pulses. Each bit lasts BIT_CYCLES system clocks, so rising edges are BIT_CYCLES apart. The clock is low for the first BIT_CYCLES/2 cycles of a bit and high for the rest.
- R3: The load strobe stays low during the bits. It is high for one bit period, with the serial clock low, directly after the 17th pulse.
- R4: While adj_mode is low, all three bus outputs are low from the next clock on. A frame already in progress is abandoned and busy drops.
- R5: An accepted command raises busy from the next cycle until the strobe ends. A command presented while busy or while adj_mode is low gives a one-cycle cmd_reject pulse on the next cycle and sends no frame.
- R6: A frame with 17 pulses whose module field equals strap_id writes its gain into the register selected by its channel field.
- R7: A frame whose module field differs from strap_id changes no register and raises no error.
- R8: If the strobe rises after a pulse count other than 17, the receiver gives a one-cycle frame_err pulse and writes nothing. If no pulse arrives for 2*BIT_CYCLES clocks, a partial frame is dropped and the count restarts.
- R9: Reset clears all 16 registers to 0. rd_gain shows the register chosen by rd_channel one clock after rd_channel is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adj_mode | input | 1 | Gain-adjust mode select; bus is silent when low |
| cmd_valid | input | 1 | Host command strobe |
| cmd_module | input | 5 | Target module address |
| cmd_channel | input | 4 | Target channel address |
| cmd_gain | input | 8 | Gain code to send |
| busy | output | 1 | Frame in progress |
| cmd_reject | output | 1 | One-cycle pulse: command refused |
| ser_clk | output | 1 | Transmitted serial clock |
| ser_data | output | 1 | Transmitted serial data |
| ser_load | output | 1 | Transmitted load strobe |
| rx_clk | input | 1 | Received serial clock (asynchronous) |
| rx_data | input | 1 | Received serial data (asynchronous) |
| rx_load | input | 1 | Received load strobe (asynchronous) |
| strap_id | input | 5 | This module's address strap |
| rd_channel | input | 4 | Readback channel select |
| rd_gain | output | 8 | Readback gain value |
| frame_err | output | 1 | One-cycle pulse: strobe after wrong pulse count |

## Verification
The bench goes after the frame edges. Frames of 16 and 18 pulses are injected directly on the receiver lines. A receiver that skipped the count check would latch a shifted gain into a wrong channel instead of flagging frame_err. A second command during busy must be refused, with the first frame going out intact; a design that reloaded its shift register would send a mixed or doubled frame. Dropping adj_mode in mid-frame must leave the lines low and the receiver's partial count cleared; a design that kept the stale pulses would mark the next good frame as an error. Random frames aimed half at other module addresses check that a mismatch never disturbs a register, and readback at channels 0 and 15 exposes channel decode that is off by one.

// File: rtl/gl_pkg.sv
package gl_pkg;
    localparam int MOD_W   = 5;
    localparam int CH_W    = 4;
    localparam int GAIN_W  = 8;
    localparam int FRAME_W = MOD_W + CH_W + GAIN_W;
    localparam int NUM_CH  = 2 ** CH_W;

    typedef struct packed {
        logic [MOD_W-1:0]  module_id;
        logic [CH_W-1:0]   chan;
        logic [GAIN_W-1:0] gain;
    } gl_frame_t;

    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_SHIFT  = 2'd1,
        TX_STROBE = 2'd2
    } tx_state_e;

    function automatic logic addr_hit(input gl_frame_t f, input logic [MOD_W-1:0] strap);
        return f.module_id == strap;
    endfunction
endpackage

// File: rtl/gl_sync.sv
module gl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gl_tx.sv
module gl_tx
    import gl_pkg::*;
#(
    parameter int BIT_CYCLES = 40000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      adj_mode,
    input  logic      cmd_valid,
    input  gl_frame_t cmd_frame,
    output logic      busy,
    output logic      cmd_reject,
    output logic      sclk,
    output logic      sdata,
    output logic      sload
);
    localparam int TW   = $clog2(BIT_CYCLES + 1);
    localparam int BW   = $clog2(FRAME_W + 1);
    localparam int HALF = BIT_CYCLES / 2;
    localparam logic [TW-1:0] T_LAST = TW'(BIT_CYCLES - 1);
    localparam logic [TW-1:0] T_RISE = TW'(HALF - 1);
    localparam logic [BW-1:0] B_LAST = BW'(FRAME_W - 1);

    tx_state_e          state;
    logic [TW-1:0]      tick;
    logic [BW-1:0]      bit_idx;
    logic [FRAME_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= TX_IDLE;
            tick       <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            sclk       <= 1'b0;
            sdata      <= 1'b0;
            sload      <= 1'b0;
            cmd_reject <= 1'b0;
        end else begin
            cmd_reject <= cmd_valid && (state != TX_IDLE || !adj_mode);
            if (!adj_mode) begin
                state <= TX_IDLE;
                tick  <= '0;
                sclk  <= 1'b0;
                sdata <= 1'b0;
                sload <= 1'b0;
            end else begin
                case (state)
                    TX_IDLE: begin
                        if (cmd_valid) begin
                            shreg   <= cmd_frame;
                            sdata   <= cmd_frame[FRAME_W-1];
                            sclk    <= 1'b0;
                            tick    <= '0;
                            bit_idx <= '0;
                            state   <= TX_SHIFT;
                        end
                    end
                    TX_SHIFT: begin
                        if (tick == T_LAST) begin
                            tick <= '0;
                            sclk <= 1'b0;
                            if (bit_idx == B_LAST) begin
                                sdata <= 1'b0;
                                sload <= 1'b1;
                                state <= TX_STROBE;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                                shreg   <= shreg << 1;
                                sdata   <= shreg[FRAME_W-2];
                            end
                        end else begin
                            tick <= tick + 1'b1;
                            if (tick == T_RISE) sclk <= 1'b1;
                        end
                    end
                    TX_STROBE: begin
                        if (tick == T_LAST) begin
                            tick  <= '0;
                            sload <= 1'b0;
                            state <= TX_IDLE;
                        end else begin
                            tick <= tick + 1'b1;
                        end
                    end
                    default: state <= TX_IDLE;
                endcase
            end
        end
    end

    assign busy = (state != TX_IDLE);
endmodule

// File: rtl/gl_rx.sv
module gl_rx
    import gl_pkg::*;
#(
    parameter int BIT_CYCLES = 40000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    input  logic              sdata_in,
    input  logic              sload_in,
    input  logic [MOD_W-1:0]  strap,
    output logic              wr_en,
    output logic [CH_W-1:0]   wr_ch,
    output logic [GAIN_W-1:0] wr_gain,
    output logic              frame_err
);
    localparam int IDLE_LIM = 2 * BIT_CYCLES;
    localparam int IW       = $clog2(IDLE_LIM + 1);
    localparam int PW       = $clog2(FRAME_W + 2) + 1;
    localparam logic [IW-1:0] I_MAX  = IW'(IDLE_LIM);
    localparam logic [PW-1:0] P_FULL = PW'(FRAME_W);
    localparam logic [PW-1:0] P_SAT  = {PW{1'b1}};

    logic [2:0] raw, syn, prev;
    assign raw = {sload_in, sdata_in, sclk_in};

    for (genvar g = 0; g < 3; g++) begin : g_sync
        gl_sync #(.STAGES(2)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw[g]),
            .q   (syn[g])
        );
    end

    logic clk_rise, load_rise;
    assign clk_rise  = syn[0] && !prev[0];
    assign load_rise = syn[2] && !prev[2];

    gl_frame_t     shreg;
    logic [PW-1:0] pcnt;
    logic [IW-1:0] idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev      <= '0;
            shreg     <= '0;
            pcnt      <= '0;
            idle      <= '0;
            wr_en     <= 1'b0;
            wr_ch     <= '0;
            wr_gain   <= '0;
            frame_err <= 1'b0;
        end else begin
            prev      <= syn;
            wr_en     <= 1'b0;
            frame_err <= 1'b0;
            if (load_rise) begin
                pcnt <= '0;
                idle <= '0;
                if (pcnt == P_FULL) begin
                    if (addr_hit(shreg, strap)) begin
                        wr_en   <= 1'b1;
                        wr_ch   <= shreg.chan;
                        wr_gain <= shreg.gain;
                    end
                end else begin
                    frame_err <= 1'b1;
                end
            end else if (clk_rise) begin
                shreg <= {shreg[FRAME_W-2:0], syn[1]};
                if (pcnt != P_SAT) pcnt <= pcnt + 1'b1;
                idle <= '0;
            end else if (idle != I_MAX) begin
                idle <= idle + 1'b1;
            end else begin
                pcnt <= '0;
            end
        end
    end
endmodule

// File: rtl/gl_regfile.sv
module gl_regfile
    import gl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [GAIN_W-1:0] wr_gain,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [GAIN_W-1:0] rd_gain
);
    logic [GAIN_W-1:0] regs [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                   regs[i] <= '0;
            else if (wr_en && wr_ch == CH_W'(i))       regs[i] <= wr_gain;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_gain <= '0;
        else     rd_gain <= regs[rd_ch];
    end
endmodule

// File: rtl/gain_link_top.sv
module gain_link_top
    import gl_pkg::*;
#(
    parameter int BIT_CYCLES = 40000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adj_mode,
    input  logic              cmd_valid,
    input  logic [MOD_W-1:0]  cmd_module,
    input  logic [CH_W-1:0]   cmd_channel,
    input  logic [GAIN_W-1:0] cmd_gain,
    output logic              busy,
    output logic              cmd_reject,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_load,
    input  logic              rx_clk,
    input  logic              rx_data,
    input  logic              rx_load,
    input  logic [MOD_W-1:0]  strap_id,
    input  logic [CH_W-1:0]   rd_channel,
    output logic [GAIN_W-1:0] rd_gain,
    output logic              frame_err
);
    gl_frame_t         cmd_frame;
    logic              wr_en;
    logic [CH_W-1:0]   wr_ch;
    logic [GAIN_W-1:0] wr_gain;

    assign cmd_frame = '{module_id: cmd_module, chan: cmd_channel, gain: cmd_gain};

    gl_tx #(.BIT_CYCLES(BIT_CYCLES)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .adj_mode   (adj_mode),
        .cmd_valid  (cmd_valid),
        .cmd_frame  (cmd_frame),
        .busy       (busy),
        .cmd_reject (cmd_reject),
        .sclk       (ser_clk),
        .sdata      (ser_data),
        .sload      (ser_load)
    );

    gl_rx #(.BIT_CYCLES(BIT_CYCLES)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .sclk_in   (rx_clk),
        .sdata_in  (rx_data),
        .sload_in  (rx_load),
        .strap     (strap_id),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .wr_gain   (wr_gain),
        .frame_err (frame_err)
    );

    gl_regfile u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_gain (wr_gain),
        .rd_ch   (rd_channel),
        .rd_gain (rd_gain)
    );
endmodule

// File: rtl/gain_link_chk.sv
module gain_link_chk (
    input logic clk,
    input logic rst,
    input logic adj_mode,
    input logic cmd_valid,
    input logic busy,
    input logic cmd_reject,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_load
);
    logic       prev_clk;
    logic [5:0] pulses;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_clk <= 1'b0;
            pulses   <= '0;
        end else begin
            prev_clk <= ser_clk;
            if (!busy)                     pulses <= '0;
            else if (ser_clk && !prev_clk) pulses <= pulses + 1'b1;
        end
    end

    // R1: data steady while the serial clock is high
    a_r1_data_steady: assert property (@(posedge clk) disable iff (rst)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    // R2: strobe follows exactly 17 clock pulses
    a_r2_seventeen_pulses: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_load) |-> (pulses == 6'd17));

    // R3: serial clock low while strobe is high
    a_r3_strobe_clk_low: assert property (@(posedge clk) disable iff (rst)
        ser_load |-> !ser_clk);

    // R4: lines silent outside gain-adjust mode
    a_r4_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        !adj_mode |=> (!ser_clk && !ser_data && !ser_load && !busy));

    // R5: command during busy is refused
    a_r5_reject_busy: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy) |=> cmd_reject);

    // R5: busy covers the strobe
    a_r5_busy_strobe: assert property (@(posedge clk) disable iff (rst)
        ser_load |-> busy);
endmodule

bind gain_link_top gain_link_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .adj_mode   (adj_mode),
    .cmd_valid  (cmd_valid),
    .busy       (busy),
    .cmd_reject (cmd_reject),
    .ser_clk    (ser_clk),
    .ser_data   (ser_data),
    .ser_load   (ser_load)
);

// File: tb/gain_link_top_tb_top.sv
module gain_link_top_tb_top;
    localparam int BIT = 8;
    localparam logic [4:0] STRAP = 5'd9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic adj_mode = 1'b0, cmd_valid = 1'b0;
    logic [4:0] cmd_module = '0;
    logic [3:0] cmd_channel = '0, rd_channel = '0;
    logic [7:0] cmd_gain = '0;
    logic busy, cmd_reject, ser_clk, ser_data, ser_load, frame_err;
    logic [7:0] rd_gain;
    logic inject = 1'b0, inj_clk = 1'b0, inj_data = 1'b0, inj_load = 1'b0;
    logic rx_clk, rx_data, rx_load;

    assign rx_clk  = inject ? inj_clk  : ser_clk;
    assign rx_data = inject ? inj_data : ser_data;
    assign rx_load = inject ? inj_load : ser_load;

    always #10 clk = ~clk;

    gain_link_top #(.BIT_CYCLES(BIT)) dut_i (
        .clk(clk), .rst(rst), .adj_mode(adj_mode), .cmd_valid(cmd_valid),
        .cmd_module(cmd_module), .cmd_channel(cmd_channel), .cmd_gain(cmd_gain),
        .busy(busy), .cmd_reject(cmd_reject), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .rx_clk(rx_clk), .rx_data(rx_data), .rx_load(rx_load),
        .strap_id(STRAP), .rd_channel(rd_channel), .rd_gain(rd_gain), .frame_err(frame_err)
    );

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] model [16];

    // bus monitor
    int cyc = 0, last_rise = 0, mon_cnt = 0, last_cnt = 0, frames = 0;
    int gap_err = 0, errs = 0, quiet_viol = 0;
    logic [16:0] mon_bits = '0, last_frame = '0;
    logic p_clk = 0, p_load = 0, p_adj = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (!busy) mon_cnt = 0;
            if (ser_clk && !p_clk) begin
                if (mon_cnt > 0 && (cyc - last_rise) != BIT) gap_err++;
                mon_bits = {mon_bits[15:0], ser_data};
                mon_cnt++;
                last_rise = cyc;
            end
            if (ser_load && !p_load) begin
                last_frame = mon_bits;
                last_cnt = mon_cnt;
                frames++;
                mon_cnt = 0;
            end
            if (frame_err) errs++;
            if (!adj_mode && !p_adj && (ser_clk || ser_data || ser_load)) quiet_viol++;
        end
        p_clk = ser_clk; p_load = ser_load; p_adj = adj_mode;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic readback(input logic [3:0] c, input string req);
        @(negedge clk); rd_channel = c;
        @(negedge clk); @(negedge clk);
        chk(req, rd_gain, model[c]);
    endtask

    task automatic send(input logic [4:0] m, input logic [3:0] c, input logic [7:0] g);
        int f0, e0;
        f0 = frames; e0 = errs;
        @(negedge clk);
        while (busy) @(negedge clk);
        cmd_valid = 1; cmd_module = m; cmd_channel = c; cmd_gain = g;
        @(negedge clk); cmd_valid = 0;
        chk("R5 busy after accept", busy, 1);
        while (busy) @(negedge clk);
        repeat (6) @(negedge clk);
        chk("R2 one frame out", frames, f0 + 1);
        chk("R2 pulse count", last_cnt, 17);
        chk("R1 frame bits", last_frame, {m, c, g});
        chk("R7 no error on good frame", errs, e0);
        if (m == STRAP) model[c] = g;
        readback(c, m == STRAP ? "R6 write" : "R7 mismatch kept");
    endtask

    task automatic inject_frame(input logic [16:0] bits, input int npulses);
        @(negedge clk); inject = 1;
        for (int i = 0; i < npulses; i++) begin
            inj_data = (i < 17) ? bits[16 - i] : 1'b0;
            inj_clk = 0; repeat (BIT / 2) @(negedge clk);
            inj_clk = 1; repeat (BIT / 2) @(negedge clk);
        end
        inj_clk = 0; inj_data = 0; inj_load = 1;
        repeat (BIT) @(negedge clk);
        inj_load = 0;
        repeat (BIT) @(negedge clk);
        inject = 0;
    endtask

    initial begin
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 0;
        // R9: reset state
        for (int i = 0; i < 16; i++) readback(4'(i), "R9 reset zero");
        chk("R5 idle busy", busy, 0);
        chk("R4 idle lines", {ser_clk, ser_data, ser_load}, 0);

        // R4/R5: command while mode is off is refused, bus stays low
        @(negedge clk); cmd_valid = 1; cmd_module = STRAP; cmd_channel = 4'd3; cmd_gain = 8'h77;
        @(negedge clk); cmd_valid = 0;
        chk("R5 reject when mode off", cmd_reject, 1);
        chk("R4 no busy when mode off", busy, 0);
        repeat (40) @(negedge clk);
        chk("R4 no frame when mode off", frames, 0);
        readback(4'd3, "R4 register untouched");

        adj_mode = 1;
        repeat (3) @(negedge clk);
        // directed frames
        send(STRAP, 4'd0, 8'hFF);
        send(STRAP, 4'd15, 8'hA5);
        send(STRAP, 4'd15, 8'h00);
        send(STRAP, 4'd7, 8'h5A);
        send(5'd8, 4'd7, 8'h11);     // R7 mismatch
        send(5'd31, 4'd0, 8'h22);    // R7 mismatch
        chk("R2 bit period", gap_err, 0);

        // R5: second command during busy is refused, first frame intact
        begin
            int f0;
            f0 = frames;
            @(negedge clk);
            cmd_valid = 1; cmd_module = STRAP; cmd_channel = 4'd2; cmd_gain = 8'h3C;
            @(negedge clk);
            cmd_channel = 4'd4; cmd_gain = 8'hC3;
            @(negedge clk); cmd_valid = 0;
            chk("R5 reject while busy", cmd_reject, 1);
            while (busy) @(negedge clk);
            repeat (6) @(negedge clk);
            chk("R5 single frame", frames, f0 + 1);
            chk("R5 first frame kept", last_frame, {STRAP, 4'd2, 8'h3C});
            model[2] = 8'h3C;
            readback(4'd2, "R5 first write");
            readback(4'd4, "R5 rejected no write");
        end

        // R4: abort mid-frame, partial count dropped by the receiver
        begin
            int e0;
            e0 = errs;
            @(negedge clk);
            cmd_valid = 1; cmd_module = STRAP; cmd_channel = 4'd5; cmd_gain = 8'hEE;
            @(negedge clk); cmd_valid = 0;
            repeat (60) @(negedge clk);
            adj_mode = 0;
            repeat (2) @(negedge clk);
            chk("R4 busy drops on abort", busy, 0);
            chk("R4 lines low on abort", {ser_clk, ser_data, ser_load}, 0);
            repeat (40) @(negedge clk);
            adj_mode = 1;
            readback(4'd5, "R4 aborted frame no write");
            send(STRAP, 4'd5, 8'h42);
            chk("R8 fragment dropped", errs, e0);
        end
        chk("R4 quiet while off", quiet_viol, 0);

        // R8: wrong pulse counts injected on the receiver lines
        begin
            int e0;
            e0 = errs;
            inject_frame({STRAP, 4'd6, 8'h99}, 16);
            chk("R8 short frame error", errs, e0 + 1);
            readback(4'd6, "R8 short frame no write");
            inject_frame({STRAP, 4'd6, 8'h99}, 18);
            chk("R8 long frame error", errs, e0 + 2);
            readback(4'd6, "R8 long frame no write");
            inject_frame({STRAP, 4'd6, 8'h99}, 17);
            chk("R8 exact frame no error", errs, e0 + 2);
            model[6] = 8'h99;
            readback(4'd6, "R6 injected write");
        end

        // random frames
        for (int k = 0; k < 24; k++) begin
            logic [4:0] m;
            m = ($urandom % 2) ? STRAP : 5'($urandom);
            send(m, 4'($urandom), 8'($urandom));
        end
        chk("R2 bit period random", gap_err, 0);
        for (int i = 0; i < 16; i++) readback(4'(i), "R9 final readback");

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule